// File: doc/BRIEF.md
# Three-Pair Complementary PWM Generator

This block produces six pulse-width-modulated outputs grouped as three pairs. Each pair has a high-side and a low-side output and its own 16-bit up-counter. A shared prescaler divides the system clock by a selectable power of two to drive all three counters. A pair's period comes from a length value. The high side rises and falls at two compare values. The low side rises when the count reaches the length value and falls at a third compare value. In H-bridge mode the low side is also dropped at the moment the high side falls.

Software reaches the block through one write port, which loads a control word and four values for each pair. Length and compare writes go into shadow registers. A running pair copies them into its working set only when its counter wraps, so no period is built from a mix of old and new values. When any counter wraps, an end-of-period interrupt flag is set. A one-cycle clear input acknowledges it. After reset the block is disabled in H-bridge mode, so every output stays low until software enables it.

Top module: `pwm_pair_unit`

## Requirements
- R1: There are three independent pairs. Pair p (p = 0..2) has its own length and compares, written at address 4*(p+1)+f, where f = 0 is the length, f = 1 is compare 0, f = 2 is compare 1 and f = 3 is compare 2.
- R2: While the block is enabled, each pair's counter starts at 0 in the cycle after enable and advances by one on each prescaler tick. When it equals the length value, it wraps to 0 on the next tick, so a period lasts length+1 ticks.
- R3: The control word is written at address 0. Its fields are: bit 0 enable, bits 3:1 prescaler select s, bit 4 H-bridge mode. A tick occurs once every 2^(s+1) clock cycles, with the first tick 2^(s+1) cycles after enable.
- R4: The high-side output goes high when the count equals compare 0 and low when the count equals compare 1. If both match the same count, low wins.
- R5: The low-side output goes high when the count equals the length value and low when the count equals compare 2. If both match the same count, low wins.
- R6: In H-bridge mode (bit 4 = 1), the low-side output also goes low on the count at which the high-side output falls. In standard mode (bit 4 = 0) the high side does not affect the low side.
- R7: After reset the control word is 0x0012 (disabled, select 1, H-bridge mode), and all six outputs and the interrupt flag are low. The outputs stay low even after length and compare values are written.
- R8: Writing the enable bit to 0 drives all six outputs low one clock after the control word takes the new value.
- R9: Length and compare writes made while a pair runs have no effect until that pair's counter next wraps to 0.
- R10: The interrupt flag is set on the cycle after any pair's counter wraps. It stays set until a clear pulse arrives in a cycle with no wrap, and is then low.
- R11: Writes to addresses 1 to 3 and control bits above bit 4 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| irq_clr | input | 1 | Interrupt flag clear pulse |
| pwm_hi | output | 3 | High-side outputs, bit p for pair p |
| pwm_lo | output | 3 | Low-side outputs, bit p for pair p |
| irq | output | 1 | End-of-period interrupt flag |

## Verification
The bench builds the block with its default parameters: three pairs, 16-bit counters and a 3-bit prescaler select. This covers the full set of divide ratios, including divide by 256. Each pair gets a different length value, so the three counters wrap at different times, and the interrupt flag is hit by wraps that are not aligned. The configurations cover compare values of 0, compares equal to the length, coinciding compares, and compare 2 falling after compare 1 in both modes. One case rewrites a compare in the middle of a period.

// File: rtl/pwm_pair_pkg.sv
// Package: shared control-word layout and register field codes for the
// three-pair PWM unit. Assumes the control word occupies bits 4:0.
package pwm_pair_pkg;

    // Control word as it sits in write-data bits 4:0
    typedef struct packed {
        logic       hbridge;   // bit 4: H-bridge interlock mode
        logic [2:0] psel;      // bits 3:1: prescaler select
        logic       en;        // bit 0: run enable
    } ctrl_t;

    localparam logic [4:0] CTRL_RESET = 5'h12;

    // Field codes inside one pair's four-word address slot
    localparam int FLD_LEN  = 0;
    localparam int FLD_CMP0 = 1;
    localparam int FLD_CMP1 = 2;
    localparam int FLD_CMP2 = 3;
    localparam int NUM_FLDS = 4;

endpackage

// File: rtl/pwm_ctrl_regs.sv
// Module: control register and write decoder.
// Holds the control word, produces a one-cycle start pulse on the rising
// edge of enable, and decodes the pair field write strobes.
// Assumes: address 0 is the control word, pair p field f sits at 4*(p+1)+f.
module pwm_ctrl_regs
    import pwm_pair_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    parameter int ADDR_W    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [4:0]                      wr_ctrl,
    output ctrl_t                           ctrl,
    output logic                            start,
    output logic [NUM_PAIRS*NUM_FLDS-1:0]   fld_wr
);

    logic en_d;

    // Control word storage, reset to disabled H-bridge mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= ctrl_t'(CTRL_RESET);
        end else if (wr_en && (wr_addr == '0)) begin
            ctrl <= ctrl_t'(wr_ctrl);
        end
    end

    // Delayed enable for start-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d <= 1'b0;
        end else begin
            en_d <= ctrl.en;
        end
    end

    assign start = ctrl.en && !en_d;

    // Field strobes for each pair slot
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        for (genvar f = 0; f < NUM_FLDS; f++) begin : g_fld
            assign fld_wr[p*NUM_FLDS+f] =
                wr_en && (wr_addr == ADDR_W'((p + 1) * NUM_FLDS + f));
        end
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start); // R2

endmodule

// File: rtl/pwm_prescaler.sv
// Module: shared clock prescaler.
// Emits a one-cycle tick every 2^(psel+1) clocks while enabled; the
// counter is held at zero while disabled so the first tick lands a full
// division after enable.
module pwm_prescaler #(
    parameter int PSEL_W = 3,
    localparam int PRE_W = 1 << PSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);

    logic [PRE_W-1:0]  pre_cnt;
    logic [PSEL_W:0]   shamt;
    logic [PRE_W-1:0]  mask;

    assign shamt = {1'b0, psel} + 1'b1;
    assign mask  = ~({PRE_W{1'b1}} << shamt);
    assign tick  = en && ((pre_cnt & mask) == mask);

    // Free-running divider count, cleared when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3

endmodule

// File: rtl/pwm_pair_channel.sv
// Module: one PWM pair (counter, shadow/working values, two outputs).
// Evaluates the compares on the count value the counter moves to (or on
// zero at start), so outputs change in the same edge as the count.
// Assumes tick is never asserted in the same cycle as start.
module pwm_pair_channel
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 start,
    input  logic                 tick,
    input  logic                 hbridge,
    input  logic [NUM_FLDS-1:0]  fld_wr,
    input  logic [CNT_W-1:0]     wr_val,
    output logic                 hi,
    output logic                 lo,
    output logic                 wrap
);

    logic [CNT_W-1:0] sh  [NUM_FLDS];
    logic [CNT_W-1:0] act [NUM_FLDS];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] val;
    logic [CNT_W-1:0] e_len, e_c0, e_c1, e_c2;
    logic             ev, hi_fall, hi_n, lo_n;

    assign wrap = tick && (cnt == act[FLD_LEN]);
    assign nxt  = wrap ? '0 : cnt + 1'b1;
    assign val  = tick ? nxt : cnt;
    assign ev   = tick || start;

    // Values that govern this event: new set on a wrap, else working set
    assign e_len = wrap ? sh[FLD_LEN]  : act[FLD_LEN];
    assign e_c0  = wrap ? sh[FLD_CMP0] : act[FLD_CMP0];
    assign e_c1  = wrap ? sh[FLD_CMP1] : act[FLD_CMP1];
    assign e_c2  = wrap ? sh[FLD_CMP2] : act[FLD_CMP2];

    // Next output levels; a fall beats a rise on the same count
    always_comb begin
        hi_fall = hi && (val == e_c1);
        if (val == e_c1)      hi_n = 1'b0;
        else if (val == e_c0) hi_n = 1'b1;
        else                  hi_n = hi;
        if ((val == e_c2) || (hbridge && hi_fall)) lo_n = 1'b0;
        else if (val == e_len)                     lo_n = 1'b1;
        else                                       lo_n = lo;
    end

    // Shadow registers written from the port at any time
    always_ff @(posedge clk) begin
        for (int f = 0; f < NUM_FLDS; f++) begin
            if (!rst_n)          sh[f] <= '0;
            else if (fld_wr[f])  sh[f] <= wr_val;
        end
    end

    // Working set follows shadow while idle, reloads only on a wrap
    always_ff @(posedge clk) begin
        for (int f = 0; f < NUM_FLDS; f++) begin
            if (!rst_n)              act[f] <= '0;
            else if (!en || wrap)    act[f] <= sh[f];
        end
    end

    // Period counter
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (tick)     cnt <= nxt;
    end

    // Output levels, forced low while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hi <= 1'b0;
            lo <= 1'b0;
        end else if (ev) begin
            hi <= hi_n;
            lo <= lo_n;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= act[FLD_LEN])); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0)); // R2
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(cnt)); // R2
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hi && !lo)); // R8
    AST_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hi) && $past(hbridge) && $past(en)) |-> !lo); // R6
    AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (act[FLD_LEN] == $past(sh[FLD_LEN]))); // R9

endmodule

// File: rtl/pwm_pair_unit.sv
// Module: top of the three-pair PWM unit.
// Ties the control registers, shared prescaler and one channel per pair
// together and keeps the end-of-period interrupt flag.
// Assumes CNT_W >= 5 so the control word fits in the write data.
module pwm_pair_unit
    import pwm_pair_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    parameter int CNT_W     = 16,
    parameter int PSEL_W    = 3,
    localparam int ADDR_W   = $clog2((NUM_PAIRS + 1) * NUM_FLDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic                 irq_clr,
    output logic [NUM_PAIRS-1:0] pwm_hi,
    output logic [NUM_PAIRS-1:0] pwm_lo,
    output logic                 irq
);

    ctrl_t                          ctrl;
    logic                           start;
    logic                           tick;
    logic [NUM_PAIRS*NUM_FLDS-1:0]  fld_wr;
    logic [NUM_PAIRS-1:0]           wrap;

    pwm_ctrl_regs #(
        .NUM_PAIRS (NUM_PAIRS),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_ctrl (wr_data[4:0]),
        .ctrl    (ctrl),
        .start   (start),
        .fld_wr  (fld_wr)
    );

    pwm_prescaler #(
        .PSEL_W (PSEL_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl.en),
        .psel  (ctrl.psel),
        .tick  (tick)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chan
        pwm_pair_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ctrl.en),
            .start   (start),
            .tick    (tick),
            .hbridge (ctrl.hbridge),
            .fld_wr  (fld_wr[p*NUM_FLDS +: NUM_FLDS]),
            .wr_val  (wr_data),
            .hi      (pwm_hi[p]),
            .lo      (pwm_lo[p]),
            .wrap    (wrap[p])
        );
    end

    // Interrupt flag: a wrap sets it and outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (|wrap)    irq <= 1'b1;
        else if (irq_clr)  irq <= 1'b0;
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> irq); // R10
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(|wrap)) |=> !irq); // R10

endmodule

// File: tb/tb_pwm_pair_unit.sv
// Bench: a table of pair configurations run against a cycle model built
// from the requirements, then directed checks for reset, disable and the
// interrupt clear.
module tb_pwm_pair_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;
    localparam int NV = 7;
    // columns: psel, len, c0, c1, c2, hbridge, mid-write edge, mid value
    localparam int VEC [NV][8] = '{
        '{0, 7, 1, 4, 6, 1, 0, 0},
        '{0, 7, 1, 4, 6, 0, 0, 0},
        '{1, 5, 0, 3, 5, 1, 0, 0},
        '{2, 4, 2, 4, 1, 0, 0, 0},
        '{0, 6, 3, 3, 2, 1, 0, 0},
        '{7, 1, 0, 1, 0, 0, 0, 0},
        '{0, 9, 2, 7, 8, 1, 5, 3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        irq_clr = 1'b0;
    logic [NP-1:0] pwm_hi, pwm_lo;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    // reference model state
    int mc [NP];
    int ma [NP][4];
    int ms [NP][4];
    bit mh [NP];
    bit ml [NP];
    bit mirq;

    pwm_pair_unit dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq_clr (irq_clr),
        .pwm_hi  (pwm_hi),
        .pwm_lo  (pwm_lo),
        .irq     (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(addr);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // apply one event at count value v to pair p of the model
    task automatic model_event(input int p, input int v, input bit hb);
        bit hf;
        bit nh;
        bit nl;
        hf = mh[p] && (v == ma[p][2]);
        if (v == ma[p][2])      nh = 1'b0;
        else if (v == ma[p][1]) nh = 1'b1;
        else                    nh = mh[p];
        if ((v == ma[p][3]) || (hb && hf)) nl = 1'b0;
        else if (v == ma[p][0])            nl = 1'b1;
        else                               nl = ml[p];
        mh[p] = nh;
        ml[p] = nl;
    endtask

    task automatic run_vec(input int vi);
        int psel, len, hb, midj, midv, dd, nn;
        int bad_j [NP+1];
        int bad_a [NP+1];
        int bad_e [NP+1];
        string tag;
        psel = VEC[vi][0];
        len  = VEC[vi][1];
        hb   = VEC[vi][5];
        midj = VEC[vi][6];
        midv = VEC[vi][7];
        dd   = 1 << (psel + 1);
        nn   = 2 * dd * (len + 3) + 4;
        for (int p = 0; p <= NP; p++) bad_j[p] = -1;

        wr(0, 0);
        clear_irq();
        // unmapped addresses must not matter (R11)
        for (int a = 1; a < 4; a++) wr(a, 16'hFFFF);
        for (int p = 0; p < NP; p++) begin
            ms[p][0] = len + p;
            ms[p][1] = VEC[vi][2];
            ms[p][2] = VEC[vi][3];
            ms[p][3] = VEC[vi][4];
            for (int f = 0; f < 4; f++) begin
                wr(4 * (p + 1) + f, ms[p][f]);
                ma[p][f] = ms[p][f];
            end
            mc[p] = 0;
            mh[p] = 1'b0;
            ml[p] = 1'b0;
        end
        mirq = 1'b0;
        // upper control bits set to junk (R11)
        wr(0, 16'hFFE0 | (hb << 4) | (psel << 1) | 1);

        for (int j = 1; j <= nn; j++) begin
            @(posedge clk);
            for (int p = 0; p < NP; p++) begin
                if (j == 1) begin
                    model_event(p, 0, hb[0]);
                end else if ((j % dd) == 0) begin
                    if (mc[p] == ma[p][0]) begin
                        mc[p] = 0;
                        mirq  = 1'b1;
                        for (int f = 0; f < 4; f++) ma[p][f] = ms[p][f];
                    end else begin
                        mc[p] = mc[p] + 1;
                    end
                    model_event(p, mc[p], hb[0]);
                end
            end
            if (j == midj) ms[0][2] = midv;
            @(negedge clk);
            if (j == midj) wr_en = 1'b0;
            for (int p = 0; p < NP; p++) begin
                int a;
                int e;
                a = {pwm_hi[p], pwm_lo[p]};
                e = {mh[p], ml[p]};
                if (a != e && bad_j[p] < 0) begin
                    bad_j[p] = j; bad_a[p] = a; bad_e[p] = e;
                end
            end
            if (irq != mirq && bad_j[NP] < 0) begin
                bad_j[NP] = j; bad_a[NP] = irq; bad_e[NP] = mirq;
            end
            if (j + 1 == midj) begin
                wr_en   = 1'b1;
                wr_addr = 4'd6;
                wr_data = 16'(midv);
            end
        end

        for (int p = 0; p < NP; p++) begin
            if (vi == 6)
                tag = $sformatf("R9 R4 R5 R6 vector %0d pair %0d {hi,lo} at edge %0d",
                                vi, p, bad_j[p]);
            else
                tag = $sformatf("R1 R2 R3 R4 R5 R6 R11 vector %0d pair %0d {hi,lo} at edge %0d",
                                vi, p, bad_j[p]);
            chk(bad_j[p] < 0, tag, bad_a[p], bad_e[p]);
        end
        chk(bad_j[NP] < 0, $sformatf("R10 vector %0d irq at edge %0d", vi, bad_j[NP]),
            bad_a[NP], bad_e[NP]);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state
        chk(pwm_hi == '0 && pwm_lo == '0, "R7 outputs after reset",
            {pwm_hi, pwm_lo}, 0);
        chk(irq == 1'b0, "R7 irq after reset", irq, 0);

        // R7: default control word is disabled even with values loaded
        wr(4, 3);
        wr(5, 0);
        wr(6, 2);
        wr(7, 1);
        repeat (40) @(negedge clk);
        chk(pwm_hi == '0 && pwm_lo == '0, "R7 outputs stay low under default control",
            {pwm_hi, pwm_lo}, 0);
        chk(irq == 1'b0, "R7 irq stays low under default control", irq, 0);

        // table of configurations
        for (int vi = 0; vi < NV; vi++) run_vec(vi);

        // R8: disable forces outputs low
        wr(0, 16'h0010);
        @(negedge clk);
        chk(pwm_hi == '0 && pwm_lo == '0, "R8 outputs after disable",
            {pwm_hi, pwm_lo}, 0);

        // R10: flag holds until cleared, then clears
        repeat (5) @(negedge clk);
        chk(irq == 1'b1, "R10 irq held without clear", irq, 1);
        clear_irq();
        chk(irq == 1'b0, "R10 irq after clear pulse", irq, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule